// File: doc/BRIEF.md
# Multi-Mode Conversion Result Buffer

This block holds the results produced by a two-converter, six-channel acquisition core and hands them to a host over a 16-bit parallel read port. The core reports each finished conversion as a latch event. The event carries a pair index and two 12-bit samples: the first sample belongs to the even channel of the pair and the second to the odd channel.

The host picks how data leaves the block with a 3-bit mode input and a read strobe. It can fetch one named channel. It can step a round-robin pointer across all six channels. It can also drain results in the order the latch events arrived, which is how three back-to-back acquisitions of one pair can be kept before the host reads any of them. Every output word carries its own channel tag and a valid flag, so the host never needs side information to interpret a word.

Top module: `rb_result_buffer`

## Requirements
- R1: A synchronous active-low reset clears the output word to zero, clears the overflow flag, marks every channel empty, empties the queue and returns the round-robin pointer to channel 0.
- R2: The output word has the channel tag in bits 15:13, the valid flag in bit 12 and the sample in bits 11:0. It changes only on a clock edge at which the read strobe is high and is held unchanged otherwise.
- R3: A latch event with pair index p (0 to 2) stores its first sample in channel 2p and its second sample in channel 2p+1, and marks both channels valid.
- R4: A read with mode 0 to 5 returns the word of that channel (tag = mode) and clears that channel's valid flag.
- R5: Reading a channel whose valid flag is clear returns its tag with valid 0 and sample field 0.
- R6: A read with mode 6 returns the channel at the round-robin pointer, clears that channel's valid flag and advances the pointer by one, wrapping from channel 5 to channel 0.
- R7: A read with mode 7 pops the oldest queued sample. Queue order follows the order of the latch events, and within one event the even channel comes before the odd channel.
- R8: The queue holds six samples, so one pair can be latched three times before any read, and all six samples come back in order.
- R9: A latch event that finds fewer than two free queue slots is left out of the queue, although the channel registers are still updated. It sets an overflow flag that stays high until reset.
- R10: A mode-7 read while the queue is empty returns an all-zero word.
- R11: Channel reads (modes 0 to 6) leave the queue unchanged, and queue pops leave the channel valid flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Latch event strobe |
| wr_pair | input | 2 | Channel pair index of the latch event |
| wr_d0 | input | 12 | Sample for the even channel of the pair |
| wr_d1 | input | 12 | Sample for the odd channel of the pair |
| rd_en | input | 1 | Read strobe |
| rd_mode | input | 3 | 0-5 single channel, 6 round-robin, 7 queue |
| rd_word | output | 16 | Registered read result {tag, valid, sample} |
| overflow | output | 1 | Sticky flag for a latch event the queue could not take |

## Verification
The stimulus latches the three pairs out of channel order and then reads them back three ways: one named channel twice, a full round-robin sweep past the wrap, and a queue drain. The drain tells arrival order apart from channel order. A second pattern latches one pair three times and then a fourth time. This separates a queue that keeps all six samples and refuses the extra event from one that overwrites or loses older entries. It also shows that the channel register still takes the newest sample. Reads of empty channels and of an empty queue, done right after reset and after a drain, separate a cleared valid flag from stale data.

// File: rtl/rb_pkg.sv
// Package: shared widths, mode codes and word layout for the result buffer.
// Assumes a 3-bit channel tag, so at most three pairs (six channels).
package rb_pkg;
    localparam int DATA_W = 12;
    localparam int CH_W   = 3;
    localparam int PAIR_W = CH_W - 1;
    localparam int WORD_W = CH_W + 1 + DATA_W;

    localparam logic [CH_W-1:0] MODE_CYCLE = 3'd6;
    localparam logic [CH_W-1:0] MODE_QUEUE = 3'd7;

    // Host-visible output word
    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic              vld;
        logic [DATA_W-1:0] data;
    } rb_word_t;

    // Queue entry: channel tag and sample
    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } rb_entry_t;
endpackage

// File: rtl/rb_regfile.sv
// Channel register file: one sample and one valid flag per channel.
// A latch event writes both channels of a pair. A read-clear drops one
// valid flag. A write takes priority over a clear in the same cycle.
// Assumes NUM_PAIRS <= 3.
module rb_regfile
    import rb_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [DATA_W-1:0] wr_d0,
    input  logic [DATA_W-1:0] wr_d1,
    input  logic              rd_clr,
    input  logic [CH_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    localparam int NUM_CH = 2 * NUM_PAIRS;

    logic [DATA_W-1:0] mem [NUM_CH];
    logic [NUM_CH-1:0] vld;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(g / 2);
        localparam logic [CH_W-1:0]   MY_CH   = CH_W'(g);
        logic hit_wr;
        assign hit_wr = wr_en && (wr_pair == MY_PAIR);

        // Store a sample on a latch event; clear the flag when it is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
                vld[g] <= 1'b0;
            end else if (hit_wr) begin
                mem[g] <= (g % 2 == 1) ? wr_d1 : wr_d0;
                vld[g] <= 1'b1;
            end else if (rd_clr && rd_idx == MY_CH) begin
                vld[g] <= 1'b0;
            end
        end
    end

    // Read mux: the selected channel, or empty for an index out of range.
    always_comb begin
        rd_data = '0;
        rd_vld  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_idx == CH_W'(i)) begin
                rd_data = mem[i];
                rd_vld  = vld[i];
            end
        end
    end

    p_write_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pair < PAIR_W'(NUM_PAIRS)) |=>
            (vld[{$past(wr_pair), 1'b0}] && vld[{$past(wr_pair), 1'b1}]));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && rd_idx < CH_W'(NUM_CH) && !(wr_en && wr_pair == rd_idx[CH_W-1:1]))
            |=> !vld[$past(rd_idx)]);
endmodule

// File: rtl/rb_pair_fifo.sv
// Arrival-order queue of 2*NUM_PAIRS tagged samples. A push stores a whole
// pair (even channel first) and needs two free slots. A pop removes one
// entry. A push that lacks room is dropped and sets a sticky overflow flag.
module rb_pair_fifo
    import rb_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PAIR_W-1:0] push_pair,
    input  logic [DATA_W-1:0] push_d0,
    input  logic [DATA_W-1:0] push_d1,
    input  logic              pop,
    output rb_entry_t         head,
    output logic              empty,
    output logic              overflow
);
    localparam int DEPTH = 2 * NUM_PAIRS;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rb_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic [CNT_W-1:0] count;
    logic             room, accept, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty  = (count == '0);
    assign room   = (count <= CNT_W'(DEPTH - 2));
    assign accept = push && room && (push_pair < PAIR_W'(NUM_PAIRS));
    assign do_pop = pop && !empty;
    assign head   = mem[rptr];

    // Write both samples of an accepted pair into consecutive slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (accept) begin
            mem[wptr]      <= '{ch: {push_pair, 1'b0}, data: push_d0};
            mem[nxt(wptr)] <= '{ch: {push_pair, 1'b1}, data: push_d1};
        end
    end

    // Move the pointers and the occupancy count; latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            wptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wptr <= nxt(nxt(wptr));
            if (do_pop) rptr <= nxt(rptr);
            count <= count + (accept ? CNT_W'(2) : CNT_W'(0))
                           - (do_pop ? CNT_W'(1) : CNT_W'(0));
            if (push && !room) overflow <= 1'b1;
        end
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_drop_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !room && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/rb_cycle_ptr.sv
// Round-robin channel pointer: steps by one on each advance and wraps
// from the last channel to channel 0.
module rb_cycle_ptr
    import rb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [CH_W-1:0] ptr
);
    // Step the pointer on each round-robin read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (adv)    ptr <= (ptr == CH_W'(NUM_CH - 1)) ? '0 : ptr + CH_W'(1);
    end

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < CH_W'(NUM_CH));

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == CH_W'(NUM_CH - 1)) |=> (ptr == '0));
endmodule

// File: rtl/rb_result_buffer.sv
// Top of the result buffer. Decodes the read mode and steers one read to
// the register file, the round-robin pointer or the queue. Registers the
// chosen 16-bit word and holds it until the next read. Assumes NUM_PAIRS <= 3
// so that codes 6 and 7 never name a channel.
module rb_result_buffer
    import rb_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [DATA_W-1:0] wr_d0,
    input  logic [DATA_W-1:0] wr_d1,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_mode,
    output logic [WORD_W-1:0] rd_word,
    output logic              overflow
);
    localparam int NUM_CH = 2 * NUM_PAIRS;

    logic              is_queue, is_cycle;
    logic [CH_W-1:0]   ch_sel, ptr;
    logic [DATA_W-1:0] rf_data;
    logic              rf_vld, q_empty;
    rb_entry_t         q_head;
    rb_word_t          next_word;

    assign is_queue = (rd_mode == MODE_QUEUE);
    assign is_cycle = (rd_mode == MODE_CYCLE);
    assign ch_sel   = is_cycle ? ptr : rd_mode;

    rb_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_d0(wr_d0), .wr_d1(wr_d1),
        .rd_clr(rd_en && !is_queue), .rd_idx(ch_sel),
        .rd_data(rf_data), .rd_vld(rf_vld)
    );

    rb_pair_fifo #(.NUM_PAIRS(NUM_PAIRS)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .push_pair(wr_pair), .push_d0(wr_d0), .push_d1(wr_d1),
        .pop(rd_en && is_queue),
        .head(q_head), .empty(q_empty), .overflow(overflow)
    );

    rb_cycle_ptr #(.NUM_CH(NUM_CH)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .adv(rd_en && is_cycle), .ptr(ptr)
    );

    // Form the word the current read would return.
    always_comb begin
        if (is_queue) begin
            next_word = q_empty ? '0 : '{ch: q_head.ch, vld: 1'b1, data: q_head.data};
        end else begin
            next_word = '{ch: ch_sel, vld: rf_vld, data: rf_vld ? rf_data : '0};
        end
    end

    // Capture the word on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_word <= '0;
        else if (rd_en) rd_word <= next_word;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_word));

    p_empty_queue_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_queue && q_empty) |=> (rd_word == '0));

    p_direct_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_mode < MODE_CYCLE) |=> (rd_word[WORD_W-1 -: CH_W] == $past(rd_mode)));
endmodule

// File: tb/tb_rb_result_buffer.sv
`timescale 1ns/1ps
module tb_rb_result_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_pair = '0;
    logic [11:0] wr_d0 = '0, wr_d1 = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_mode = '0;
    logic [15:0] rd_word;
    logic        overflow;

    int total = 0, fails = 0;
    bit done = 1'b0;
    logic chk_pend = 1'b0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    rb_result_buffer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair),
        .wr_d0(wr_d0), .wr_d1(wr_d1), .rd_en(rd_en), .rd_mode(rd_mode),
        .rd_word(rd_word), .overflow(overflow)
    );

    function automatic logic [15:0] mk(input int ch, input bit v, input int d);
        return {ch[2:0], v, d[11:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one scoreboard entry per read, compared after the capturing edge.
    always @(posedge clk) chk_pend <= rd_en & rst_n;
    always @(negedge clk) begin
        if (chk_pend && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rd_word, exp_q.pop_front());
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int p, input int d0, input int d1);
        wr_en = 1'b1; wr_pair = p[1:0]; wr_d0 = d0[11:0]; wr_d1 = d1[11:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: queue the expected word, then issue a one-cycle read.
    task automatic rd(input int m, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_mode = m[2:0];
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1 word", rd_word, 16'h0000);
        check("R1 overflow", {15'd0, overflow}, 16'd0);
        rd(7, 16'h0000, "R10 empty queue after reset");
        rd(0, mk(0, 0, 0), "R5 empty channel 0");
        rd(6, mk(0, 0, 0), "R6 pointer starts at 0");
        do_reset();

        // Pairs latched out of channel order
        wr(1, 'h111, 'h222);
        wr(0, 'hAAA, 'hBBB);
        wr(2, 'h5A5, 'hA5A);
        rd(3, mk(3, 1, 'h222), "R3 R4 direct read ch3");
        rd(3, mk(3, 0, 0),     "R4 R5 ch3 cleared");
        rd(7, mk(2, 1, 'h111), "R7 R11 queue intact after direct reads");
        rd(6, mk(0, 1, 'hAAA), "R6 cycle ch0");
        rd(6, mk(1, 1, 'hBBB), "R6 cycle ch1");
        rd(6, mk(2, 1, 'h111), "R11 pop kept ch2 valid");
        rd(6, mk(3, 0, 0),     "R6 cycle ch3 empty");
        rd(6, mk(4, 1, 'h5A5), "R6 cycle ch4");
        rd(6, mk(5, 1, 'hA5A), "R6 cycle ch5");
        rd(6, mk(0, 0, 0),     "R6 wrap to ch0");
        rd(7, mk(3, 1, 'h222), "R7 order 2");
        rd(7, mk(0, 1, 'hAAA), "R7 order 3");
        rd(7, mk(1, 1, 'hBBB), "R7 order 4");
        rd(7, mk(4, 1, 'h5A5), "R7 order 5");
        rd(7, mk(5, 1, 'hA5A), "R7 order 6");
        rd(7, 16'h0000,        "R10 drained queue");
        check("R9 no overflow yet", {15'd0, overflow}, 16'd0);

        // One pair latched three times, then once more
        wr(2, 'h100, 'h200);
        wr(2, 'h101, 'h201);
        wr(2, 'h102, 'h202);
        check("R8 full without overflow", {15'd0, overflow}, 16'd0);
        wr(2, 'h103, 'h203);
        check("R9 overflow set", {15'd0, overflow}, 16'd1);
        rd(4, mk(4, 1, 'h103), "R9 register takes dropped sample");
        repeat (3) @(negedge clk);
        check("R2 word held without read", rd_word, mk(4, 1, 'h103));
        rd(7, mk(4, 1, 'h100), "R8 entry 1");
        rd(7, mk(5, 1, 'h200), "R8 entry 2");
        rd(7, mk(4, 1, 'h101), "R8 entry 3");
        rd(7, mk(5, 1, 'h201), "R8 entry 4");
        rd(7, mk(4, 1, 'h102), "R8 entry 5");
        rd(7, mk(5, 1, 'h202), "R8 entry 6");
        rd(7, 16'h0000,        "R9 dropped pair absent");
        @(negedge clk);
        check("R9 overflow sticky", {15'd0, overflow}, 16'd1);
        do_reset();
        check("R1 overflow cleared", {15'd0, overflow}, 16'd0);
        check("R1 word cleared", rd_word, 16'h0000);
        rd(5, mk(5, 0, 0), "R1 channel flags cleared");
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule